// File: doc/BRIEF.md
# Refill-Path Signature Checker

This block sits on the refill path between memory and the instruction cache. When the cache misses, the miss logic pulses `miss_start` and the block opens a burst. Memory then sends the refill line as seventeen words: sixteen instruction words, then one signature word. The instruction words pass straight through to the cache with no added latency. The signature word is taken out of the stream and never reaches the cache.

While the instruction words go by, the block folds each one into a multiple-input signature register. The register's feedback taps come from a secret key, and the block samples that key when the burst opens. After the signature word is accepted, the block pulses `done` for one cycle. On that cycle `fail` says whether the computed signature differs from the received one. Traffic that arrives while no burst is open is accepted and thrown away, so cache hits never start a check.

Top module: `refill_sig_check`

## Requirements
- R1: During a burst, each of the first LINE_WORDS (16) accepted words goes to the cache in the same cycle. `out_data` equals `in_data`, `out_valid` equals `in_valid`, and `in_ready` equals `out_ready`, so the block adds no stall cycles.
- R2: `out_last` is high together with `out_valid` only on the sixteenth instruction word (word index 15) of the burst.
- R3: The word after the sixteenth is the signature word. It is always accepted (`in_ready`=1) and never forwarded (`out_valid`=0).
- R4: The signature register starts each burst at zero. For every accepted instruction word it becomes `((s << 1) ^ (s[31] ? key : 0)) ^ word`.
- R5: In the cycle after the signature word is accepted, `done` is high for exactly one cycle. `fail` is high only together with `done`. It is high when the received signature differs from the register value, or when `in_last` was low on the signature word.
- R6: The key is sampled in the cycle `miss_start` is high. A change of `key` later in the burst does not change the result.
- R7: While no burst is open, words are accepted (`in_ready`=1) and dropped. No `out_valid` and no `done` come from them.
- R8: A `miss_start` always opens a new burst with a cleared register. If it comes during an open burst, it restarts that burst. If it comes in the same cycle as a signature word is accepted, the old burst is still reported on `done`/`fail` and the new burst starts cleanly.
- R9: After synchronous active-low reset, `out_valid`, `done` and `fail` are low and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| key | input | 32 | Secret tap mask for the signature register |
| miss_start | input | 1 | Pulse: an instruction cache miss opens a refill burst |
| in_valid | input | 1 | Memory side word valid |
| in_data | input | 32 | Memory side word |
| in_last | input | 1 | Memory marks the signature word |
| in_ready | output | 1 | Block can accept the memory word |
| out_valid | output | 1 | Instruction word valid toward the cache |
| out_data | output | 32 | Instruction word toward the cache |
| out_last | output | 1 | Marks the last instruction word of the line |
| out_ready | input | 1 | Cache can accept a word |
| done | output | 1 | One-cycle pulse: verdict available |
| fail | output | 1 | Signature mismatch or malformed burst, valid with done |

## Verification
Two things can fall in the same cycle: the verdict of one burst, which comes from accepting its signature word, and the opening of the next burst by `miss_start`. The bench raises `miss_start` in the very cycle the signature word is taken. It then checks that `done`/`fail` still match the old line. It also checks that the following line, sent with no further pulse, verifies against a signature computed from a zero seed and the key sampled in that shared cycle. Random back-pressure, key changes during a burst and restarts in mid-line cover the other orderings.

// File: rtl/rsc_pkg.sv
// Package: shared types for the refill signature checker.
// Assumes nothing beyond the phase encoding used by the sequencer.
package rsc_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WORDS = 2'd1,
        PH_SIG   = 2'd2
    } phase_t;
endpackage

// File: rtl/rsc_misr.sv
// Module: key-tapped multiple-input signature register.
// On clear it loads a zero seed and latches the key. On upd it folds one word in,
// using the latched key as the feedback tap mask. Clear wins over upd.
module rsc_misr #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [WORD_W-1:0] key_in,
    input  logic              upd,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] sig
);
    logic [WORD_W-1:0] state_q;
    logic [WORD_W-1:0] key_q;
    logic [WORD_W-1:0] fb;

    // feedback term: the key taps, applied when the MSB is set
    always_comb fb = state_q[WORD_W-1] ? key_q : '0;

    // state register: zero seed on clear, fold a word on upd
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            state_q <= '0;
        end else if (upd) begin
            state_q <= {state_q[WORD_W-2:0], 1'b0} ^ fb ^ word;
        end
    end

    // key latch: sampled only when a burst opens
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q <= '0;
        end else if (clear) begin
            key_q <= key_in;
        end
    end

    assign sig = state_q;

    // R6: the key copy holds still for the whole burst
    a_r6_key_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> $stable(key_q));
    // R4: a burst start leaves a zero seed
    a_r4_zero_seed: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (state_q == '0));
endmodule

// File: rtl/rsc_seq.sv
// Module: burst sequencer. It tracks the phase and the word index, steers the
// handshakes and marks the last instruction word. It assumes memory sends
// LINE_WORDS instruction words and then one signature word.
module rsc_seq
    import rsc_pkg::*;
#(
    parameter int LINE_WORDS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic miss_start,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic out_valid,
    output logic out_last,
    output logic word_en,
    output logic sig_en
);
    localparam int CNT_W = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(LINE_WORDS - 1);

    phase_t           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic             fire;

    // handshake steering: pass-through while instruction words flow, sink otherwise
    always_comb begin
        in_ready  = (phase_q == PH_WORDS) ? out_ready : 1'b1;
        out_valid = (phase_q == PH_WORDS) && in_valid;
        out_last  = out_valid && (cnt_q == LAST_IDX);
        fire      = in_valid && in_ready;
        word_en   = fire && (phase_q == PH_WORDS);
        sig_en    = fire && (phase_q == PH_SIG);
    end

    // phase and word index: a miss always restarts, otherwise step through the line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else if (miss_start) begin
            phase_q <= PH_WORDS;
            cnt_q   <= '0;
        end else if (sig_en) begin
            phase_q <= PH_IDLE;
        end else if (word_en) begin
            if (cnt_q == LAST_IDX) begin
                phase_q <= PH_SIG;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R3: after the last instruction word is handed over, nothing more goes to the cache
    a_r3_sig_stripped: assert property (@(posedge clk) disable iff (!rst_n)
        (out_last && out_ready && !miss_start) |=> !out_valid);
    // R1: no word goes out unless memory offers one
    a_r1_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> in_valid);
    // R7: an idle block never refuses a word
    a_r7_idle_sink: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE) |-> in_ready);
endmodule

// File: rtl/refill_sig_check.sv
// Module: top of the refill signature checker. It forwards the instruction words
// of a miss refill, strips the trailing signature word, and reports a one-cycle
// verdict. It assumes the miss logic pulses miss_start before each refill.
module refill_sig_check #(
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] key,
    input  logic              miss_start,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              out_last,
    input  logic              out_ready,
    output logic              done,
    output logic              fail
);
    logic              word_en;
    logic              sig_en;
    logic [WORD_W-1:0] sig_calc;
    logic              done_q;
    logic              fail_q;

    rsc_seq #(.LINE_WORDS(LINE_WORDS)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .miss_start(miss_start),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_last  (out_last),
        .word_en   (word_en),
        .sig_en    (sig_en)
    );

    rsc_misr #(.WORD_W(WORD_W)) misr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (miss_start),
        .key_in(key),
        .upd   (word_en),
        .word  (in_data),
        .sig   (sig_calc)
    );

    // data path: instruction words go straight through
    assign out_data = in_data;

    // verdict register: one-cycle done with the compare result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            done_q <= sig_en;
            fail_q <= sig_en && ((sig_calc != in_data) || !in_last);
        end
    end

    assign done = done_q;
    assign fail = fail_q;

    // R5: done is a single-cycle pulse
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R5: fail only accompanies done
    a_r5_fail_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> done);
    // R5: a verdict follows an accepted word
    a_r5_done_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(in_valid && in_ready));
endmodule

// File: tb/refill_sig_check_tb_top.sv
module refill_sig_check_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] key = '0;
    logic        miss_start = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_last;
    logic        out_ready = 1'b1;
    logic        done;
    logic        fail;

    int total = 0;
    int bad = 0;
    logic [31:0] wbuf [16];

    always #10 clk = ~clk;

    refill_sig_check dut_i (
        .clk(clk), .rst_n(rst_n), .key(key), .miss_start(miss_start),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .out_last(out_last), .out_ready(out_ready), .done(done), .fail(fail)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // reference signature per R4, seed zero
    function automatic logic [31:0] model_sig(input logic [31:0] k);
        logic [31:0] s = '0;
        for (int i = 0; i < 16; i++)
            s = {s[30:0], 1'b0} ^ (s[31] ? k : 32'h0) ^ wbuf[i];
        return s;
    endfunction

    task automatic fill_words();
        for (int i = 0; i < 16; i++) wbuf[i] = $urandom;
    endtask

    task automatic open_burst(input logic [31:0] k);
        @(negedge clk);
        in_valid = 1'b0;
        key = k;
        miss_start = 1'b1;
        @(negedge clk);
        miss_start = 1'b0;
    endtask

    // offer one word under random gaps/back-pressure until accepted; checks R1-R3
    task automatic send_word(input logic [31:0] d, input bit last, input bit is_sig,
                             input int idx, input bit with_miss,
                             input logic [31:0] next_key);
        bit fired;
        do begin
            @(negedge clk);
            in_data = d;
            in_last = last;
            in_valid = with_miss ? 1'b1 : ($urandom % 4 != 0);
            out_ready = ($urandom % 4 != 0);
            if (with_miss) begin
                miss_start = 1'b1;
                key = next_key;
            end
            #1;
            if (in_valid) begin
                if (!is_sig) begin
                    chk(out_valid == 1'b1, "R1 out_valid", 32'(out_valid), 32'h1);
                    chk(out_data == d, "R1 out_data", out_data, d);
                    chk(in_ready == out_ready, "R1 ready pass", 32'(in_ready), 32'(out_ready));
                    chk(out_last == (idx == 15), "R2 out_last", 32'(out_last), 32'(idx == 15));
                end else begin
                    chk(in_ready == 1'b1, "R3 sig accepted", 32'(in_ready), 32'h1);
                    chk(out_valid == 1'b0, "R3 sig stripped", 32'(out_valid), 32'h0);
                end
            end
            fired = in_valid && in_ready;
        end while (!fired);
    endtask

    // sixteen words plus signature; burst already opened by caller
    task automatic run_body(input logic [31:0] k, input bit corrupt, input bit bad_last,
                            input bit key_flip, input bit miss_with_sig,
                            input logic [31:0] next_key, input string tag);
        logic [31:0] exp_sig;
        exp_sig = model_sig(k);
        if (key_flip) key = ~k ^ 32'h5A5A_0001;
        for (int i = 0; i < 16; i++) send_word(wbuf[i], 1'b0, 1'b0, i, 1'b0, 32'h0);
        send_word(exp_sig ^ {31'h0, corrupt}, !bad_last, 1'b1, 16, miss_with_sig, next_key);
        @(negedge clk);
        in_valid = 1'b0;
        miss_start = 1'b0;
        chk(done == 1'b1, {tag, " R5 done"}, 32'(done), 32'h1);
        chk(fail == (corrupt || bad_last), {tag, " R5 fail"}, 32'(fail),
            32'(corrupt || bad_last));
        @(negedge clk);
        chk(done == 1'b0, {tag, " R5 pulse end"}, 32'(done), 32'h0);
        chk(fail == 1'b0, {tag, " R5 fail low"}, 32'(fail), 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] k1, k2, s1, s2;
        void'($urandom(32'd20240611));
        // R9: reset state
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R9 out_valid", 32'(out_valid), 32'h0);
        chk(done == 1'b0, "R9 done", 32'(done), 32'h0);
        chk(fail == 1'b0, "R9 fail", 32'(fail), 32'h0);
        rst_n = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);

        // R7: traffic with no miss is sunk
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data = $urandom;
            in_last = (i == 5);
            out_ready = 1'b1;
            #1;
            chk(in_ready == 1'b1, "R7 idle ready", 32'(in_ready), 32'h1);
            chk(out_valid == 1'b0, "R7 idle no forward", 32'(out_valid), 32'h0);
            chk(done == 1'b0, "R7 idle no done", 32'(done), 32'h0);
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk(done == 1'b0, "R7 idle no done after last", 32'(done), 32'h0);

        // R4: all-zero words with key 0 give a zero signature; pass then corrupt
        for (int i = 0; i < 16; i++) wbuf[i] = '0;
        chk(model_sig(32'h0) == 32'h0, "R4 zero line", model_sig(32'h0), 32'h0);
        open_burst(32'h0);
        run_body(32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, "zero");
        // R4: single-bit word exercises shifting and feedback taps
        for (int i = 0; i < 16; i++) wbuf[i] = (i == 0) ? 32'h8000_0000 : 32'h0;
        open_burst(32'h04C1_1DB7);
        run_body(32'h04C1_1DB7, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, "R4 taps");
        open_burst(32'h04C1_1DB7);
        run_body(32'h04C1_1DB7, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, "R4 corrupt");

        // R5: missing in_last on the signature word is reported
        fill_words();
        open_burst(32'hDEAD_BEEF);
        run_body(32'hDEAD_BEEF, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0, "R5 no last");

        // R4: different keys give different signatures; the wrong key's value fails
        fill_words();
        wbuf[0] = 32'hFFFF_FFFF;
        k1 = 32'h1234_5679;
        k2 = 32'h8765_4321;
        s1 = model_sig(k1);
        s2 = model_sig(k2);
        chk(s1 != s2, "R4 key dependence", s1, s2);
        open_burst(k1);
        for (int i = 0; i < 16; i++) send_word(wbuf[i], 1'b0, 1'b0, i, 1'b0, 32'h0);
        send_word(s2, 1'b1, 1'b1, 16, 1'b0, 32'h0);
        @(negedge clk);
        in_valid = 1'b0;
        chk(done && fail == (s1 != s2), "R4 wrong key sig", 32'(fail), 32'h1);

        // R6: key changes during the burst are ignored
        fill_words();
        open_burst(32'hA5A5_0F0F);
        run_body(32'hA5A5_0F0F, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0, "R6 key flip");

        // R8: restart in mid-burst
        fill_words();
        open_burst(32'h0BAD_F00D);
        for (int i = 0; i < 5; i++) send_word($urandom, 1'b0, 1'b0, i, 1'b0, 32'h0);
        open_burst(32'h0BAD_F00D);
        run_body(32'h0BAD_F00D, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, "R8 restart");

        // R8: miss_start in the same cycle as the signature word
        fill_words();
        open_burst(32'h1357_9BDF);
        k2 = 32'hCAFE_0123;
        run_body(32'h1357_9BDF, 1'b1, 1'b0, 1'b0, 1'b1, k2, "R8 overlap old");
        fill_words();
        run_body(k2, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, "R8 overlap new");

        // random bursts
        for (int n = 0; n < 30; n++) begin
            logic [31:0] kr;
            bit cr;
            kr = $urandom;
            cr = ($urandom % 3 == 0);
            fill_words();
            open_burst(kr);
            run_body(kr, cr, 1'b0, ($urandom % 2 == 1), 1'b0, 32'h0, "R1 random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule